// File: doc/BRIEF.md
# Timer-Paced SPI DAC Command Sender

This block keeps an external dual-channel 12-bit SPI DAC updated at a fixed rate without help from a processor. A free-running period counter produces one update event per period. At each event the block reads the next entry from a small sample table and adds the channel, gain and output-enable fields to form a 16-bit write command. It then shifts the command out on SCK and SDO. The table index wraps at a programmable last entry, so a short waveform repeats for as long as the block runs.

The chip select comes from a dual-compare stage that runs off the same counter. It goes low a few clocks before the update event and goes high again at a second programmable count. The designer sets the compare values so that the select window covers the whole 32-clock shift. SCK is the system clock divided by two and idles low. SDO changes only when SCK falls, so the DAC can sample on each rising edge. If the window closes before the shift is done, the shift is cut off and SCK returns to idle.

Top module: `dacsnd_sender`

## Requirements
- R1: While reset is asserted and directly after it, cs_n is 1, sck is 0 and sdo is 0.
- R2: Each frame sends the 16-bit word {chan_b, 0, gain_unity, out_enable, sample[11:0]} most significant bit first. Bit 15 is the channel (1 = B), bit 14 is always 0, bit 13 is gain (1 = unity), bit 12 is the active-high enable and bits 11:0 are the sample.
- R3: The counter runs from 0 up to `period` and then returns to 0. A frame starts once every period+1 clocks.
- R4: cs_n falls on the clock edge that follows a counter value of period-4. The first SCK rising edge comes 5 clocks after cs_n falls.
- R5: cs_n rises on the clock edge that follows a counter value of `cs_rise_at`, so cs_n stays low for cs_rise_at+5 clocks. If both compares match on the same count, the falling compare wins.
- R6: SCK is clk/2 and is never high for two cycles in a row. A complete frame has 16 rising edges, and the first and last of them are 30 clocks apart.
- R7: sdo never changes on a rising SCK edge.
- R8: Each frame advances the table index by one. After entry `tbl_last` the index returns to 0.
- R9: SCK is low in every cycle where cs_n is high and was also high in the cycle before. If cs_n rises during a shift, the frame is cut off after the rising edges that fall inside the window, and normal frames resume afterwards.
- R10: A table write shows up in the first frame that reads that entry after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; SCK is derived from it |
| rst_n | input | 1 | Synchronous active-low reset |
| period | input | CNT_W | Last count of the update period (at least 5) |
| cs_rise_at | input | CNT_W | Count after which chip select is released |
| chan_b | input | 1 | Channel field: 1 selects output B |
| gain_unity | input | 1 | Gain field: 1 selects unity gain |
| out_enable | input | 1 | Enable field: 0 shuts the DAC output down |
| tbl_we | input | 1 | Sample table write strobe |
| tbl_waddr | input | AW | Sample table write address |
| tbl_wdata | input | 12 | Sample value to write |
| tbl_last | input | AW | Index of the last table entry played |
| cs_n | output | 1 | Active-low chip select to the DAC |
| sck | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data, MSB first |

## Verification
The assertions check every cycle that cs_n only changes on the counts its two compares select, that SCK never stays high for two cycles, that sdo holds still across each SCK rise and that SCK stays idle while deselected. Only the bench scenarios show the things that span whole frames: the bit content of the command word under different field settings, the period-to-period spacing, the walk of the table index and its wrap, a window closed early partway through a shift, and a table entry updated between frames.

// File: rtl/dacsnd_pkg.sv
// Shared widths and the DAC command word layout.
package dacsnd_pkg;
    localparam int CMD_W  = 16;
    localparam int DATA_W = 12;

    // Command word; the field order is fixed by the DAC's decoder.
    typedef struct packed {
        logic              chan_b;      // bit 15
        logic              zero;        // bit 14
        logic              gain_unity;  // bit 13
        logic              active;      // bit 12, active-low shutdown on the wire
        logic [DATA_W-1:0] code;        // bits 11:0
    } dac_cmd_t;

    function automatic dac_cmd_t make_cmd(input logic chan_b,
                                          input logic gain_unity,
                                          input logic active,
                                          input logic [DATA_W-1:0] code);
        dac_cmd_t c;
        c.chan_b     = chan_b;
        c.zero       = 1'b0;
        c.gain_unity = gain_unity;
        c.active     = active;
        c.code       = code;
        return c;
    endfunction
endpackage

// File: rtl/dacsnd_timer.sv
// Period counter: counts 0..period and returns to 0. The tick is high in the
// cycle that holds the final count. Assumes period >= 5. A count already past
// a newly lowered period still wraps on the next clock.
module dacsnd_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             tick
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Marks the final count of each period.
    assign tick = (cnt >= period);

    // Advances the count and wraps it at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + ONE;
    end
endmodule

// File: rtl/dacsnd_csgen.sv
// Dual-compare select generator: drives cs_n low one clock after the count
// equals period-LEAD and high one clock after it equals rise_at. The falling
// compare wins if both match on the same count.
module dacsnd_csgen #(
    parameter int CNT_W = 16,
    parameter int LEAD  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] rise_at,
    output logic             cs_n
);
    localparam logic [CNT_W-1:0] LEAD_V = CNT_W'(LEAD);

    logic fall_hit;
    logic rise_hit;

    // Compare matches for the two edges of the select pulse.
    assign fall_hit = (cnt == period - LEAD_V);
    assign rise_hit = (cnt == rise_at);

    // Registers the select level; an edge comes one clock after its match.
    always_ff @(posedge clk) begin
        if (!rst_n)        cs_n <= 1'b1;
        else if (fall_hit) cs_n <= 1'b0;
        else if (rise_hit) cs_n <= 1'b1;
    end
endmodule

// File: rtl/dacsnd_table.sv
// Sample table with one write port and a play index. The index moves on each
// advance pulse and returns to 0 after entry 'last'. Reads are combinational
// from the current index.
module dacsnd_table #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 12,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     last,
    input  logic              advance,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [AW-1:0] STEP = AW'(1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     idx;

    // Storage: cleared by reset, written one entry at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Play index: one step per frame, wrapping after the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= '0;
        else if (advance) idx <= (idx >= last) ? '0 : idx + STEP;
    end

    // Current sample for the next frame.
    assign rd_data = mem[idx];
endmodule

// File: rtl/dacsnd_shifter.sv
// SPI shifter: clk/2 serial clock with idle low, MSB first. Data changes on
// the falling SCK edge. A load is taken only while sel_n is low. Deselecting
// stops a shift and returns SCK to idle on the next clock.
module dacsnd_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         sel_n,
    output logic         sck,
    output logic         sdo
);
    localparam int              BC_W     = $clog2(W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(W - 1);
    localparam logic [BC_W-1:0] BC_ONE   = BC_W'(1);

    logic [W-1:0]    shreg;
    logic [BC_W-1:0] bitcnt;
    logic            busy;

    // Shift sequencing: load, rising half, then falling half with a shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            busy   <= 1'b0;
            sck    <= 1'b0;
        end else if (sel_n) begin
            busy <= 1'b0;
            sck  <= 1'b0;
        end else if (load) begin
            shreg  <= word;
            bitcnt <= '0;
            busy   <= 1'b1;
            sck    <= 1'b0;
        end else if (busy) begin
            if (!sck) begin
                sck <= 1'b1;
            end else begin
                sck   <= 1'b0;
                shreg <= {shreg[W-2:0], 1'b0};
                if (bitcnt == LAST_BIT) busy <= 1'b0;
                else                    bitcnt <= bitcnt + BC_ONE;
            end
        end
    end

    // Serial data: current MSB during a shift, low otherwise.
    assign sdo = busy & shreg[W-1];
endmodule

// File: rtl/dacsnd_sender.sv
// Top: timer-paced DAC command sender. The period counter paces frames, the
// dual-compare stage frames them with cs_n, and at each tick the shifter
// loads the word built from the table entry and the field inputs.
module dacsnd_sender
    import dacsnd_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int TBL_DEPTH = 8,
    parameter int CS_LEAD   = 4,
    parameter int AW        = $clog2(TBL_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  period,
    input  logic [CNT_W-1:0]  cs_rise_at,
    input  logic              chan_b,
    input  logic              gain_unity,
    input  logic              out_enable,
    input  logic              tbl_we,
    input  logic [AW-1:0]     tbl_waddr,
    input  logic [DATA_W-1:0] tbl_wdata,
    input  logic [AW-1:0]     tbl_last,
    output logic              cs_n,
    output logic              sck,
    output logic              sdo
);
    logic [CNT_W-1:0]  tmr_cnt;
    logic              tmr_tick;
    logic [DATA_W-1:0] tbl_rd;
    dac_cmd_t          cmd;

    dacsnd_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (period),
        .cnt    (tmr_cnt),
        .tick   (tmr_tick)
    );

    dacsnd_csgen #(.CNT_W(CNT_W), .LEAD(CS_LEAD)) u_csgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (tmr_cnt),
        .period  (period),
        .rise_at (cs_rise_at),
        .cs_n    (cs_n)
    );

    dacsnd_table #(.DEPTH(TBL_DEPTH), .DATA_W(DATA_W), .AW(AW)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (tbl_we),
        .waddr   (tbl_waddr),
        .wdata   (tbl_wdata),
        .last    (tbl_last),
        .advance (tmr_tick),
        .rd_data (tbl_rd)
    );

    // Builds the command word from the fields and the current sample.
    assign cmd = make_cmd(chan_b, gain_unity, out_enable, tbl_rd);

    dacsnd_shifter #(.W(CMD_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_tick),
        .word  (cmd),
        .sel_n (cs_n),
        .sck   (sck),
        .sdo   (sdo)
    );
endmodule

// File: rtl/dacsnd_checker.sv
// Cycle-level protocol properties of the sender, bound to the top module.
module dacsnd_checker #(
    parameter int CNT_W   = 16,
    parameter int CS_LEAD = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sck,
    input logic             sdo,
    input logic [CNT_W-1:0] tmr_cnt,
    input logic [CNT_W-1:0] period,
    input logic [CNT_W-1:0] cs_rise_at
);
    localparam logic [CNT_W-1:0] LEAD_V = CNT_W'(CS_LEAD);

    AST_CS_FALL_AT_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> ($past(tmr_cnt) == $past(period) - LEAD_V)); // R4

    AST_CS_RISE_AT_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> ($past(tmr_cnt) == $past(cs_rise_at))); // R5

    AST_SCK_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        sck |=> !sck); // R6

    AST_SDO_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(sdo)); // R7

    AST_SCK_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !sck); // R9
endmodule

bind dacsnd_sender dacsnd_checker #(.CNT_W(CNT_W), .CS_LEAD(CS_LEAD)) u_dacsnd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sck        (sck),
    .sdo        (sdo),
    .tmr_cnt    (tmr_cnt),
    .period     (period),
    .cs_rise_at (cs_rise_at)
);

// File: tb/test_dacsnd_sender.sv
`timescale 1ns/1ps
module test_dacsnd_sender;
    localparam int CNT_W = 16;
    localparam int AW    = 3;
    localparam int P     = 60;
    localparam int RISE  = 42;
    localparam int SHORT = 10;

    // Vector: [31:16] expected word, [15] chan_b, [14] gain, [13] enable, [11:0] sample
    localparam logic [31:0] VEC [6] = '{
        32'h9ABC_AABC, 32'h3123_6123, 32'hAFFF_CFFF,
        32'h0000_0000, 32'hB555_E555, 32'h1800_2800
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] period = CNT_W'(P);
    logic [CNT_W-1:0] cs_rise_at = CNT_W'(RISE);
    logic             chan_b = 1'b0, gain_unity = 1'b0, out_enable = 1'b0;
    logic             tbl_we = 1'b0;
    logic [AW-1:0]    tbl_waddr = '0;
    logic [11:0]      tbl_wdata = '0;
    logic [AW-1:0]    tbl_last = '0;
    logic             cs_n, sck, sdo;

    int nchk = 0, nerr = 0;

    // Monitor state
    int cyc = 0, fall_cyc = 0, fall_iv = 0, low_len = 0, bits_at_rise = 0;
    int nbits = 0, frames = 0, rises = 0, first_sck = 0, first_abs = 0, span = 0;
    int sdo_viol = 0, desel_viol = 0;
    logic [15:0] word = '0, last_word = '0;
    logic prev_cs = 1'b1, prev_sck = 1'b0, prev_sdo = 1'b0;

    always #2.5 clk = ~clk;

    dacsnd_sender #(.CNT_W(CNT_W), .TBL_DEPTH(8)) i_dacsnd_sender (
        .clk(clk), .rst_n(rst_n), .period(period), .cs_rise_at(cs_rise_at),
        .chan_b(chan_b), .gain_unity(gain_unity), .out_enable(out_enable),
        .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
        .tbl_last(tbl_last), .cs_n(cs_n), .sck(sck), .sdo(sdo)
    );

    // Samples the serial lines away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (sck && !prev_sck) begin
            if (nbits == 0) begin
                first_sck = cyc - fall_cyc;
                first_abs = cyc;
            end
            if (sdo !== prev_sdo) sdo_viol++;
            word = {word[14:0], sdo};
            nbits++;
            if (nbits == 16) begin
                frames++;
                last_word = word;
                span = cyc - first_abs;
            end
        end
        if (sck && cs_n && prev_cs) desel_viol++;
        if (!cs_n && prev_cs) begin
            fall_iv = cyc - fall_cyc;
            fall_cyc = cyc;
            nbits = 0;
        end
        if (cs_n && !prev_cs) begin
            low_len = cyc - fall_cyc;
            bits_at_rise = nbits;
            rises++;
        end
        prev_cs = cs_n;
        prev_sck = sck;
        prev_sdo = sdo;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_frames(input int n);
        int target = frames + n;
        int t = 0;
        while (frames < target && t < 3000) begin
            @(negedge clk); #1; t++;
        end
        if (t >= 3000) chk(1'b0, "R3 frame timeout", frames, target);
    endtask

    task automatic wait_rises(input int n);
        int target = rises + n;
        int t = 0;
        while (rises < target && t < 3000) begin
            @(negedge clk); #1; t++;
        end
        if (t >= 3000) chk(1'b0, "R5 select timeout", rises, target);
    endtask

    task automatic write_entry(input int a, input logic [11:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_waddr = AW'(a); tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL R3 watchdog expired actual=%0d expected=0", frames);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [11:0] prev_d;
        // R1: reset state
        repeat (4) @(negedge clk);
        #1;
        chk(cs_n === 1'b1 && sck === 1'b0 && sdo === 1'b0, "R1 reset outputs",
            {cs_n, sck, sdo}, 3'b100);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(cs_n === 1'b1 && sck === 1'b0 && sdo === 1'b0, "R1 after release",
            {cs_n, sck, sdo}, 3'b100);

        // R2/R10: field and sample vectors through table entry 0
        for (int v = 0; v < 6; v++) begin
            @(negedge clk);
            chan_b = VEC[v][15]; gain_unity = VEC[v][14]; out_enable = VEC[v][13];
            write_entry(0, VEC[v][11:0]);
            wait_frames(2);
            chk(last_word === VEC[v][31:16], "R2 R10 command word",
                int'(last_word), int'(VEC[v][31:16]));
        end

        // R3..R7, R9: frame timing under the normal window
        wait_frames(2);
        chk(fall_iv == P + 1, "R3 frame spacing", fall_iv, P + 1);
        chk(first_sck == 5, "R4 select lead to first SCK", first_sck, 5);
        chk(low_len == RISE + 5, "R5 select low length", low_len, RISE + 5);
        chk(bits_at_rise == 16, "R6 SCK rises per frame", bits_at_rise, 16);
        chk(span == 30, "R6 SCK first-to-last rise", span, 30);
        chk(sdo_viol == 0, "R7 sdo change on SCK rise", sdo_viol, 0);
        chk(desel_viol == 0, "R9 SCK while deselected", desel_viol, 0);

        // R8: index walk and wrap over four entries
        for (int i = 0; i < 4; i++) write_entry(i, 12'h100 + 12'(i));
        @(negedge clk); tbl_last = AW'(3);
        wait_frames(2);
        prev_d = last_word[11:0];
        for (int k = 0; k < 6; k++) begin
            logic [11:0] exp_d;
            wait_frames(1);
            exp_d = 12'h100 + 12'((int'(prev_d) - 'h100 + 1) % 4);
            chk(last_word[11:0] === exp_d, "R8 index order and wrap",
                int'(last_word[11:0]), int'(exp_d));
            prev_d = last_word[11:0];
        end

        // R9: window closed partway through a shift
        @(negedge clk); cs_rise_at = CNT_W'(SHORT);
        wait_rises(3);
        chk(bits_at_rise == SHORT / 2 + 1, "R9 truncated frame bits",
            bits_at_rise, SHORT / 2 + 1);
        chk(low_len == SHORT + 5, "R5 short select low length", low_len, SHORT + 5);
        chk(desel_viol == 0, "R9 SCK idle after cut", desel_viol, 0);
        @(negedge clk); cs_rise_at = CNT_W'(RISE);
        wait_rises(2);
        chk(bits_at_rise == 16, "R9 full frames resume", bits_at_rise, 16);

        // R10: update a single-entry table between frames
        @(negedge clk); tbl_last = '0;
        chan_b = 1'b1; gain_unity = 1'b1; out_enable = 1'b1;
        write_entry(0, 12'h777);
        wait_frames(2);
        chk(last_word === 16'hB777, "R10 rewritten entry", int'(last_word), 'hB777);
        chk(sdo_viol == 0, "R7 sdo stable at rises overall", sdo_viol, 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule